// File: doc/BRIEF.md
# Paged Program Counter Unit

This block owns the instruction address of a small processor core. The address is 13 bits wide. Each clock edge selects one of six sources for the next address: reset, the fixed interrupt entry point, a full return address handed back by an external return stack, a jump or call target, a software write to the low address byte, or a plain increment. When no request is active the address holds. A 5-bit page register supplies the upper address bits that the short loads cannot carry. Software writes this register directly.

The width of the page register that takes part in a load depends on the load. A write to the low byte takes all five page bits as address bits 12:8. A jump or call carries an 11-bit literal and takes only page bits 4:3 as address bits 12:11. A return takes the popped address whole and ignores the page register. No load ever changes the page register. The unit also presents the address of the next sequential instruction, so the stack can push it on a call or an interrupt entry. Decode, program memory and the stack storage sit outside the block.

The block has no data stream. Every input is a single-cycle control or value pin that is sampled at the rising edge, and there is no back-pressure.

Top module: `pcu_top`

## Requirements
- R1: While `rst_n` is low, `pc` and `page_q` go to 0 at the next clock edge and stay there.
- R2: With only `step_en` active, `pc` becomes `pc + 1`, and 0x1FFF wraps to 0x0000.
- R3: With `low_we` as the highest active request, `pc` becomes {`page_q[4:0]`, `alu_byte`}. A carry out of an ALU sum on the low byte is lost, so bits 12:8 always come from the page register.
- R4: With `jump_en` as the highest active request, `pc` becomes {`page_q[4:3]`, `jump_lit[10:0]`}. Page bits 2:0 have no effect.
- R5: With `ret_en` as the highest active request, `pc` becomes `ret_addr`, and the page register has no effect.
- R6: With `irq_take` active, `pc` becomes 0x0004.
- R7: Priority from highest to lowest is reset, `irq_take`, `ret_en`, `jump_en`, `low_we`, `step_en`.
- R8: `page_q` changes only on `page_we`, and then to `page_din`. A load on the same edge uses the value the page register held before that edge. Returns, jumps and interrupts leave `page_q` unchanged.
- R9: `push_addr` always equals `pc + 1` modulo 2^13.
- R10: With no request active, `pc` holds its value.
- R11: `pc_low` always shows `pc[7:0]`. No port shows the upper address bits on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| page_we | input | 1 | Write strobe for the page register |
| page_din | input | 5 | New page register value |
| irq_take | input | 1 | Enter the interrupt vector |
| ret_en | input | 1 | Load the popped return address |
| ret_addr | input | 13 | Address popped from the return stack |
| jump_en | input | 1 | Jump or call with a literal target |
| jump_lit | input | 11 | Literal target from the instruction |
| low_we | input | 1 | Write the ALU result to the low address byte |
| alu_byte | input | 8 | ALU result byte |
| step_en | input | 1 | Advance to the next sequential address |
| pc | output | 13 | Current instruction address |
| pc_low | output | 8 | Readable low address byte |
| push_addr | output | 13 | Next sequential address, for pushing to the stack |
| page_q | output | 5 | Readable page register |

## Verification
The assertions assume that every control pin is a known 0 or 1 at each sampled edge after reset. They also assume that the reset is held for at least one edge before the first request. They make no assumption about which requests come together, because the priority chain resolves every combination.

The bench drives all inputs on the falling edge and clears every strobe after one cycle, so each request lasts exactly one edge. It drives some combinations of requests on purpose, to exercise the priority order.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int PCU_ADDR_W = 13;
  localparam int PCU_LOW_W  = 8;
  localparam int PCU_LIT_W  = 11;
  localparam int PCU_VECTOR = 4;

  typedef enum logic [2:0] {
    SRC_HOLD  = 3'd0,
    SRC_STEP  = 3'd1,
    SRC_LOW   = 3'd2,
    SRC_JUMP  = 3'd3,
    SRC_RET   = 3'd4,
    SRC_IRQ   = 3'd5,
    SRC_RESET = 3'd6
  } load_src_e;
endpackage

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= din;
  end
endmodule

// File: rtl/pcu_load_arbiter.sv
module pcu_load_arbiter
  import pcu_pkg::*;
(
  input  logic      rst_n,
  input  logic      irq_take,
  input  logic      ret_en,
  input  logic      jump_en,
  input  logic      low_we,
  input  logic      step_en,
  output load_src_e src
);
  // Fixed priority: the first true term wins.
  always_comb begin
    if (!rst_n)        src = SRC_RESET;
    else if (irq_take) src = SRC_IRQ;
    else if (ret_en)   src = SRC_RET;
    else if (jump_en)  src = SRC_JUMP;
    else if (low_we)   src = SRC_LOW;
    else if (step_en)  src = SRC_STEP;
    else               src = SRC_HOLD;
  end
endmodule

// File: rtl/pcu_addr_mux.sv
module pcu_addr_mux
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LOW_W  = 8,
  parameter int LIT_W  = 11,
  parameter int VECTOR = 4
) (
  input  load_src_e                src,
  input  logic [ADDR_W-1:0]        cur,
  input  logic [ADDR_W-LOW_W-1:0]  page,
  input  logic [ADDR_W-1:0]        ret_addr,
  input  logic [LIT_W-1:0]         lit,
  input  logic [LOW_W-1:0]         alu_byte,
  output logic [ADDR_W-1:0]        seq_addr,
  output logic [ADDR_W-1:0]        nxt
);
  localparam int PAGE_W = ADDR_W - LOW_W;
  localparam int HI_W   = ADDR_W - LIT_W;

  logic [ADDR_W-1:0] low_target;
  logic [ADDR_W-1:0] jump_target;

  assign seq_addr   = cur + ADDR_W'(1);
  assign low_target = {page, alu_byte};

  // A jump takes only the top HI_W page bits.
  generate
    if (HI_W > 0) begin : g_paged_jump
      assign jump_target = {page[PAGE_W-1 -: HI_W], lit};
    end else begin : g_flat_jump
      assign jump_target = lit[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_RESET: nxt = '0;
      SRC_IRQ:   nxt = ADDR_W'(VECTOR);
      SRC_RET:   nxt = ret_addr;
      SRC_JUMP:  nxt = jump_target;
      SRC_LOW:   nxt = low_target;
      SRC_STEP:  nxt = seq_addr;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int ADDR_W = PCU_ADDR_W,
  parameter int LOW_W  = PCU_LOW_W,
  parameter int LIT_W  = PCU_LIT_W,
  parameter int VECTOR = PCU_VECTOR
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     page_we,
  input  logic [ADDR_W-LOW_W-1:0]  page_din,
  input  logic                     irq_take,
  input  logic                     ret_en,
  input  logic [ADDR_W-1:0]        ret_addr,
  input  logic                     jump_en,
  input  logic [LIT_W-1:0]         jump_lit,
  input  logic                     low_we,
  input  logic [LOW_W-1:0]         alu_byte,
  input  logic                     step_en,
  output logic [ADDR_W-1:0]        pc,
  output logic [LOW_W-1:0]         pc_low,
  output logic [ADDR_W-1:0]        push_addr,
  output logic [ADDR_W-LOW_W-1:0]  page_q
);
  localparam int PAGE_W = ADDR_W - LOW_W;

  load_src_e         src;
  logic [ADDR_W-1:0] pc_nxt;
  logic [ADDR_W-1:0] seq_addr;

  pcu_page_latch #(.PAGE_W(PAGE_W)) u_page (
    .clk (clk),
    .rst_n (rst_n),
    .we (page_we),
    .din (page_din),
    .q (page_q)
  );

  pcu_load_arbiter u_arb (
    .rst_n (rst_n),
    .irq_take (irq_take),
    .ret_en (ret_en),
    .jump_en (jump_en),
    .low_we (low_we),
    .step_en (step_en),
    .src (src)
  );

  pcu_addr_mux #(
    .ADDR_W(ADDR_W), .LOW_W(LOW_W), .LIT_W(LIT_W), .VECTOR(VECTOR)
  ) u_mux (
    .src (src),
    .cur (pc),
    .page (page_q),
    .ret_addr (ret_addr),
    .lit (jump_lit),
    .alu_byte (alu_byte),
    .seq_addr (seq_addr),
    .nxt (pc_nxt)
  );

  always_ff @(posedge clk) pc <= pc_nxt;

  assign pc_low    = pc[LOW_W-1:0];
  assign push_addr = seq_addr;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int ADDR_W = 13,
  parameter int LOW_W  = 8,
  parameter int LIT_W  = 11,
  parameter int VECTOR = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     page_we,
  input logic [ADDR_W-LOW_W-1:0]  page_din,
  input logic                     irq_take,
  input logic                     ret_en,
  input logic [ADDR_W-1:0]        ret_addr,
  input logic                     jump_en,
  input logic [LIT_W-1:0]         jump_lit,
  input logic                     low_we,
  input logic [LOW_W-1:0]         alu_byte,
  input logic                     step_en,
  input logic [ADDR_W-1:0]        pc,
  input logic [LOW_W-1:0]         pc_low,
  input logic [ADDR_W-1:0]        push_addr,
  input logic [ADDR_W-LOW_W-1:0]  page_q
);
  localparam int PAGE_W = ADDR_W - LOW_W;
  localparam int HI_W   = ADDR_W - LIT_W;

  assert_reset_clears_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pc == '0 && page_q == '0));

  assert_step_adds_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !irq_take && !ret_en && !jump_en && !low_we)
    |=> pc == ADDR_W'($past(pc) + ADDR_W'(1)));

  assert_low_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (low_we && !irq_take && !ret_en && !jump_en)
    |=> pc == {$past(page_q), $past(alu_byte)});

  assert_jump_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_en && !irq_take && !ret_en)
    |=> pc == {$past(page_q[PAGE_W-1 -: HI_W]), $past(jump_lit)});

  assert_return_whole_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !irq_take) |=> pc == $past(ret_addr));

  assert_irq_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> pc == ADDR_W'(VECTOR));

  // R7: interrupt beats every other request at once
  assert_irq_over_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && ret_en && jump_en && low_we && step_en) |=> pc == ADDR_W'(VECTOR));

  assert_page_only_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !page_we |=> page_q == $past(page_q));

  assert_page_takes_din_R8: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |=> page_q == $past(page_din));

  assert_push_is_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !irq_take && !ret_en && !jump_en && !low_we)
    |=> pc == $past(push_addr));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !irq_take && !ret_en && !jump_en && !low_we) |=> $stable(pc));

  assert_low_view_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !irq_take) |=> pc_low == $past(ret_addr[LOW_W-1:0]));
endmodule

bind pcu_top pcu_checker #(
  .ADDR_W(ADDR_W), .LOW_W(LOW_W), .LIT_W(LIT_W), .VECTOR(VECTOR)
) u_chk (
  .clk (clk), .rst_n (rst_n), .page_we (page_we), .page_din (page_din),
  .irq_take (irq_take), .ret_en (ret_en), .ret_addr (ret_addr),
  .jump_en (jump_en), .jump_lit (jump_lit), .low_we (low_we),
  .alu_byte (alu_byte), .step_en (step_en), .pc (pc), .pc_low (pc_low),
  .push_addr (push_addr), .page_q (page_q)
);

// File: tb/pcu_top_test.sv
`timescale 1ns/1ps
module pcu_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        page_we;
  logic [4:0]  page_din;
  logic        irq_take;
  logic        ret_en;
  logic [12:0] ret_addr;
  logic        jump_en;
  logic [10:0] jump_lit;
  logic        low_we;
  logic [7:0]  alu_byte;
  logic        step_en;
  logic [12:0] pc;
  logic [7:0]  pc_low;
  logic [12:0] push_addr;
  logic [4:0]  page_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pcu_top uut (
    .clk (clk), .rst_n (rst_n), .page_we (page_we), .page_din (page_din),
    .irq_take (irq_take), .ret_en (ret_en), .ret_addr (ret_addr),
    .jump_en (jump_en), .jump_lit (jump_lit), .low_we (low_we),
    .alu_byte (alu_byte), .step_en (step_en), .pc (pc), .pc_low (pc_low),
    .push_addr (push_addr), .page_q (page_q)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    page_we = 0; page_din = '0; irq_take = 0; ret_en = 0; ret_addr = '0;
    jump_en = 0; jump_lit = '0; low_we = 0; alu_byte = '0; step_en = 0;
  endtask

  // One edge with the current strobes, then clear them; samples at negedge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic load_ret(input logic [12:0] a);
    ret_en = 1; ret_addr = a; tick();
  endtask

  task automatic set_page(input logic [4:0] p);
    page_we = 1; page_din = p; tick();
  endtask

  task automatic test_reset();
    load_ret(13'h0ABC);
    set_page(5'h15);
    rst_n = 0; tick(); tick();
    check("R1 pc", pc, 0);
    check("R1 page", page_q, 0);
    rst_n = 1;
  endtask

  task automatic test_step_wrap();
    load_ret(13'h0010);
    step_en = 1; tick();
    check("R2 step", pc, 13'h0011);
    load_ret(13'h1FFE);
    step_en = 1; tick();
    check("R2 to top", pc, 13'h1FFF);
    check("R9 push at top", push_addr, 0);
    step_en = 1; tick();
    check("R2 wrap", pc, 0);
    check("R9 push", push_addr, 1);
  endtask

  task automatic test_low_write();
    set_page(5'h0A);
    load_ret(13'h00F0);
    low_we = 1; alu_byte = 8'h10; tick();  // 0xF0+0x20 with carry lost
    check("R3 carry lost", pc, 13'h0A10);
    check("R11 low view", pc_low, 8'h10);
    set_page(5'h1F);
    low_we = 1; alu_byte = 8'hC3; tick();
    check("R3 full page", pc, 13'h1FC3);
  endtask

  task automatic test_jump();
    set_page(5'h1F);
    jump_en = 1; jump_lit = 11'h123; tick();
    check("R4 jump hi page", pc, 13'h1923);
    set_page(5'h08);
    jump_en = 1; jump_lit = 11'h7FF; tick();
    check("R4 jump page1", pc, 13'h0FFF);
    check("R8 page kept by jump", page_q, 5'h08);
  endtask

  task automatic test_return();
    set_page(5'h1F);
    load_ret(13'h0456);
    check("R5 return", pc, 13'h0456);
    check("R8 page kept by ret", page_q, 5'h1F);
  endtask

  task automatic test_irq();
    load_ret(13'h0321);
    check("R9 push before irq", push_addr, 13'h0322);
    irq_take = 1; tick();
    check("R6 vector", pc, 4);
    check("R8 page kept by irq", page_q, 5'h1F);
  endtask

  task automatic test_priority();
    set_page(5'h00);
    irq_take = 1; ret_en = 1; ret_addr = 13'h1111; jump_en = 1; low_we = 1; step_en = 1; tick();
    check("R7 irq first", pc, 4);
    ret_en = 1; ret_addr = 13'h1234; jump_en = 1; jump_lit = 11'h055; low_we = 1; step_en = 1; tick();
    check("R7 ret over jump", pc, 13'h1234);
    jump_en = 1; jump_lit = 11'h066; low_we = 1; alu_byte = 8'h99; step_en = 1; tick();
    check("R7 jump over low", pc, 13'h0066);
    low_we = 1; alu_byte = 8'h77; step_en = 1; tick();
    check("R7 low over step", pc, 13'h0077);
  endtask

  task automatic test_same_edge_page();
    set_page(5'h00);
    page_we = 1; page_din = 5'h18; jump_en = 1; jump_lit = 11'h011; tick();
    check("R8 old page used", pc, 13'h0011);
    check("R8 new page", page_q, 5'h18);
    jump_en = 1; jump_lit = 11'h011; tick();
    check("R8 new page used", pc, 13'h1811);
  endtask

  task automatic test_hold();
    load_ret(13'h0ACE);
    tick(); tick();
    check("R10 hold", pc, 13'h0ACE);
    check("R11 low", pc_low, 8'hCE);
  endtask

  initial begin
    idle();
    rst_n = 0;
    tick(); tick();
    check("R1 pc after reset", pc, 0);
    check("R1 page after reset", page_q, 0);
    rst_n = 1;
    test_step_wrap();
    test_low_write();
    test_jump();
    test_return();
    test_irq();
    test_priority();
    test_same_edge_page();
    test_hold();
    test_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule